// File: doc/BRIEF.md
# Quadrature Encoder Up/Down Counter

This block is a counter core with four selectable counting functions. In the tick function it counts up on a prescaled internal clock. In the two double-rate quadrature functions it counts both edges of one encoder phase, and the level of the other phase sets the direction. In the full-rate quadrature function it counts every edge of both phases, which gives four counts per encoder cycle. The count wraps between zero and a programmable ceiling. Each wrap raises a one-cycle update event.

The control inputs are level and strobe signals that a register file drives. They are enable, a 2-bit function select, a ceiling write with an optional shadow (preload) stage, a prescaler divisor, a software update strobe and a direct counter load. A two-state run machine gates all counting. In state `ST_HALT` nothing counts. In state `ST_COUNT` qualified steps are applied. The machine moves from `ST_HALT` to `ST_COUNT` on the clock edge that samples enable high, and back to `ST_HALT` on the edge that samples it low. Both encoder phases pass through a two-flop synchronizer, and edges are taken from the synchronized values.

Top module: `quad_count_core`

## Requirements
- R1: After reset, count is 0, dir_down is 0, upd_evt is 0, and both the active ceiling and the shadow ceiling hold all ones.
- R2: Counting happens only in state ST_COUNT, which is entered on the clock edge that samples enable high and left on the edge that samples it low. In ST_HALT, prescaler ticks and phase edges leave the count unchanged.
- R3: With mode = 2'b00 the count rises by one on every psc_div+1 cycles spent in ST_COUNT, with dir_down 0. Phase inputs have no effect.
- R4: With mode = 2'b01 only changes of phase_a count. The step is up when the new phase_a level differs from phase_b and down when they are equal.
- R5: With mode = 2'b10 only changes of phase_b count. The step is up when the new phase_b level equals phase_a and down when they differ.
- R6: With mode = 2'b11 a change of either phase counts, each phase under its own rule from R4 and R5. A cycle in which both synchronized phases change together does not count.
- R7: dir_down is 1 after a counted down step and 0 after a counted up step. It is unchanged by cycles without a step.
- R8: An up step taken while the count is at or above the active ceiling sets the count to 0 and pulses upd_evt for one cycle.
- R9: A down step taken at count 0 sets the count to the active ceiling and pulses upd_evt for one cycle.
- R10: With preload_en low, a ceiling write sets the active ceiling on the next clock edge.
- R11: With preload_en high, a ceiling write reaches only the shadow ceiling. The active ceiling takes the shadow value on the next wrap or update strobe. If that event falls in the same cycle as the write, the newly written value is taken.
- R12: An update strobe (ug) clears the count and the prescaler, copies the shadow ceiling into the active ceiling and pulses upd_evt. It has priority over a direct load in the same cycle.
- R13: A direct load (cnt_we) sets the count to cnt_wdata on the next edge and has priority over a counting step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request for the run machine |
| mode | input | 2 | Counting function: 00 tick, 01 phase A double-rate, 10 phase B double-rate, 11 full quadrature |
| preload_en | input | 1 | 1 routes ceiling writes through the shadow ceiling |
| ceil_we | input | 1 | Ceiling write strobe |
| ceil_wdata | input | CNT_W | Ceiling write value |
| psc_div | input | PSC_W | Prescaler divisor minus one |
| ug | input | 1 | Update strobe |
| cnt_we | input | 1 | Direct counter load strobe |
| cnt_wdata | input | CNT_W | Direct load value |
| phase_a | input | 1 | Encoder phase A (asynchronous) |
| phase_b | input | 1 | Encoder phase B (asynchronous) |
| count | output | CNT_W | Counter value |
| dir_down | output | 1 | 1 after a down step, 0 after an up step |
| upd_evt | output | 1 | One-cycle wrap or update event |

## Verification
Two pairs of functions can act in the same cycle. The first pair is the update strobe and the direct counter load. The second is an update event and a preloaded ceiling write. The bench asserts both strobes in a single cycle for each pair. For the first pair, the count must read zero afterwards. For the second, the point at which the next run of ticks wraps shows which ceiling the core kept. The randomized encoder walks produce down-wraps at zero with the shadow ceiling loaded, and every step is compared against a bench model derived from the requirement rules.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;

    typedef enum logic [1:0] {
        MODE_TICK = 2'b00,
        MODE_X2A  = 2'b01,
        MODE_X2B  = 2'b10,
        MODE_X4   = 2'b11
    } qmode_e;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_e;

    typedef struct packed {
        logic take;
        logic down;
    } step_t;

endpackage

// File: rtl/qcnt_sync.sv
module qcnt_sync #(
    parameter int NPH    = 2,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] pin,
    output logic [NPH-1:0] lvl,
    output logic [NPH-1:0] chg
);
    localparam int TOP = STAGES - 1;

    for (genvar i = 0; i < NPH; i++) begin : g_ph
        logic [STAGES-1:0] chain;
        logic              prev;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
                prev  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], pin[i]};
                prev  <= chain[TOP];
            end
        end

        assign lvl[i] = chain[TOP];
        assign chg[i] = chain[TOP] ^ prev;
    end
endmodule

// File: rtl/qcnt_prescale.sv
module qcnt_prescale #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clr,
    input  logic [PW-1:0] div,
    output logic          tick
);
    localparam logic [PW-1:0] PONE = PW'(1);

    logic [PW-1:0] pc;

    assign tick = run && (pc >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (clr) begin
            pc <= '0;
        end else if (run) begin
            pc <= (pc >= div) ? '0 : pc + PONE;
        end
    end
endmodule

// File: rtl/qcnt_qual.sv
module qcnt_qual
    import qcnt_pkg::*;
(
    input  qmode_e      mode,
    input  logic [1:0]  lvl,
    input  logic [1:0]  chg,
    input  logic        tick,
    output step_t       stp
);
    logic same;

    assign same = (lvl[0] == lvl[1]);

    always_comb begin
        stp = '0;
        unique case (mode)
            MODE_TICK: begin
                stp.take = tick;
                stp.down = 1'b0;
            end
            MODE_X2A: begin
                stp.take = chg[0];
                stp.down = same;
            end
            MODE_X2B: begin
                stp.take = chg[1];
                stp.down = !same;
            end
            MODE_X4: begin
                stp.take = chg[0] ^ chg[1];
                stp.down = chg[0] ? same : !same;
            end
        endcase
    end
endmodule

// File: rtl/quad_count_core.sv
module quad_count_core
    import qcnt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PSC_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       mode,
    input  logic             preload_en,
    input  logic             ceil_we,
    input  logic [CNT_W-1:0] ceil_wdata,
    input  logic [PSC_W-1:0] psc_div,
    input  logic             ug,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             phase_a,
    input  logic             phase_b,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             upd_evt
);
    localparam logic [CNT_W-1:0] CEIL_RST = '1;
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    run_e             st;
    qmode_e           mode_q;
    logic [1:0]       ph_lvl, ph_chg;
    logic             tick;
    step_t            stp;
    logic [CNT_W-1:0] cnt_q, ceil_q, shad_q, shadow_nxt;
    logic             dir_q, evt_q;

    assign mode_q     = qmode_e'(mode);
    assign shadow_nxt = ceil_we ? ceil_wdata : shad_q;

    qcnt_sync #(.NPH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   ({phase_b, phase_a}),
        .lvl   (ph_lvl),
        .chg   (ph_chg)
    );

    qcnt_prescale #(.PW(PSC_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   ((st == ST_COUNT) && (mode_q == MODE_TICK)),
        .clr   (ug),
        .div   (psc_div),
        .tick  (tick)
    );

    qcnt_qual u_qual (
        .mode  (mode_q),
        .lvl   (ph_lvl),
        .chg   (ph_chg),
        .tick  (tick),
        .stp   (stp)
    );

    // Run-state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_HALT;
        else        st <= enable ? ST_COUNT : ST_HALT;
    end

    // Counter, ceiling and event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            dir_q  <= 1'b0;
            evt_q  <= 1'b0;
            ceil_q <= CEIL_RST;
            shad_q <= CEIL_RST;
        end else begin
            evt_q  <= 1'b0;
            shad_q <= shadow_nxt;
            if (ug) begin
                cnt_q  <= '0;
                ceil_q <= shadow_nxt;
                evt_q  <= 1'b1;
            end else if (cnt_we) begin
                cnt_q <= cnt_wdata;
            end else begin
                unique case (st)
                    ST_HALT: begin
                    end
                    ST_COUNT: begin
                        if (stp.take) begin
                            dir_q <= stp.down;
                            if (stp.down) begin
                                if (cnt_q == '0) begin
                                    cnt_q  <= ceil_q;
                                    evt_q  <= 1'b1;
                                    ceil_q <= shadow_nxt;
                                end else begin
                                    cnt_q <= cnt_q - ONE;
                                end
                            end else if (cnt_q >= ceil_q) begin
                                cnt_q  <= '0;
                                evt_q  <= 1'b1;
                                ceil_q <= shadow_nxt;
                            end else begin
                                cnt_q <= cnt_q + ONE;
                            end
                        end
                    end
                endcase
            end
            if (ceil_we && !preload_en) ceil_q <= ceil_wdata;
        end
    end

    assign count    = cnt_q;
    assign dir_down = dir_q;
    assign upd_evt  = evt_q;
endmodule

// File: rtl/qcnt_checker.sv
module qcnt_checker
    import qcnt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ug,
    input logic             cnt_we,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic             ceil_we,
    input logic             preload_en,
    input logic [CNT_W-1:0] ceil_wdata,
    input logic [CNT_W-1:0] count,
    input logic             dir_down,
    input logic             upd_evt,
    input run_e             st,
    input logic [CNT_W-1:0] ceil_q
);
    a_r2_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALT && !ug && !cnt_we) |=> (count == $past(count)));

    a_r12_ug_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ug |=> (count == '0 && upd_evt));

    a_r13_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && !ug) |=> (count == $past(cnt_wdata)));

    a_r10_immediate_ceil: assert property (@(posedge clk) disable iff (!rst_n)
        (ceil_we && !preload_en) |=> (ceil_q == $past(ceil_wdata)));

    a_r11_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ceil_we && preload_en) |=> (ceil_q == $past(ceil_q) || upd_evt));

    a_r8_up_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_evt && !$past(ug) && !dir_down) |-> (count == '0));
endmodule

bind quad_count_core qcnt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ug         (ug),
    .cnt_we     (cnt_we),
    .cnt_wdata  (cnt_wdata),
    .ceil_we    (ceil_we),
    .preload_en (preload_en),
    .ceil_wdata (ceil_wdata),
    .count      (count),
    .dir_down   (dir_down),
    .upd_evt    (upd_evt),
    .st         (st),
    .ceil_q     (ceil_q)
);

// File: tb/quad_count_core_test.sv
module quad_count_core_test;
    localparam int W  = 8;
    localparam int PW = 4;

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, preload_en = 1'b0;
    logic ceil_we = 1'b0, ug = 1'b0, cnt_we = 1'b0, phase_a = 1'b0, phase_b = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [W-1:0]  ceil_wdata = '0, cnt_wdata = '0;
    logic [PW-1:0] psc_div = '0;
    logic [W-1:0]  count;
    logic          dir_down, upd_evt;

    int n_chk = 0, n_bad = 0, ev_seen = 0, ev_exp = 0;
    int m_cnt = 0, m_arr = 255, m_shad = 255, mp = 0;
    bit m_dir = 1'b0;

    quad_count_core #(.CNT_W(W), .PSC_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
        .preload_en(preload_en), .ceil_we(ceil_we), .ceil_wdata(ceil_wdata),
        .psc_div(psc_div), .ug(ug), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .phase_a(phase_a), .phase_b(phase_b), .count(count),
        .dir_down(dir_down), .upd_evt(upd_evt)
    );

    always #5 clk = ~clk;

    always @(negedge clk) if (rst_n && upd_evt) ev_seen++;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_step(bit down);
        m_dir = down;
        if (down) begin
            if (m_cnt == 0) begin m_cnt = m_arr; ev_exp++; m_arr = m_shad; end
            else m_cnt--;
        end else begin
            if (m_cnt >= m_arr) begin m_cnt = 0; ev_exp++; m_arr = m_shad; end
            else m_cnt++;
        end
    endtask

    task automatic do_ug(bit wc, int cv, bit wceil, int ceil_v, bit pre);
        ug = 1'b1; cnt_we = wc; cnt_wdata = W'(cv);
        ceil_we = wceil; ceil_wdata = W'(ceil_v); preload_en = pre;
        @(negedge clk);
        ug = 1'b0; cnt_we = 1'b0; ceil_we = 1'b0;
        if (wceil) m_shad = ceil_v;
        m_cnt = 0; m_arr = m_shad; mp = 0; ev_exp++;
        cyc(2);
    endtask

    task automatic wr_ceil(int v, bit pre);
        ceil_we = 1'b1; ceil_wdata = W'(v); preload_en = pre;
        @(negedge clk);
        ceil_we = 1'b0;
        m_shad = v;
        if (!pre) m_arr = v;
    endtask

    task automatic wr_cnt(int v);
        cnt_we = 1'b1; cnt_wdata = W'(v);
        @(negedge clk);
        cnt_we = 1'b0;
        m_cnt = v;
    endtask

    task automatic run_ticks(int k);
        enable = 1'b1;
        for (int i = 0; i < k; i++) begin
            phase_a = ~phase_a;
            @(negedge clk);
            mp++;
            if (mp == int'(psc_div) + 1) begin mp = 0; model_step(1'b0); end
        end
        enable = 1'b0;
        cyc(3);
    endtask

    task automatic enc_move(bit na, bit nb, string req);
        bit ea, eb, take, down;
        ea = (na != phase_a);
        eb = (nb != phase_b);
        take = 1'b0; down = 1'b0;
        unique case (mode)
            2'b01: begin take = ea; down = (na == nb); end
            2'b10: begin take = eb; down = (nb != na); end
            2'b11: begin take = ea ^ eb; down = ea ? (na == nb) : (nb != na); end
            default: ;
        endcase
        phase_a = na; phase_b = nb;
        cyc(5);
        if (take) model_step(down);
        check(req, int'(count), m_cnt);
        check("R7 dir_down", int'(dir_down), int'(m_dir));
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        check("R1 count", int'(count), 0);
        check("R1 dir_down", int'(dir_down), 0);
        check("R1 upd_evt", int'(upd_evt), 0);

        // R3 tick mode with divide by 3, phases toggling
        mode = 2'b00; psc_div = 4'd2;
        wr_ceil(9, 1'b0);
        do_ug(1'b0, 0, 1'b0, 0, 1'b0);
        run_ticks(10);
        check("R3 tick count", int'(count), m_cnt);
        check("R12 events", ev_seen, ev_exp);

        // R8 wrap at ceiling 9, R10 immediate ceiling
        psc_div = 4'd0;
        do_ug(1'b0, 0, 1'b0, 0, 1'b0);
        run_ticks(12);
        check("R8 R10 wrap count", int'(count), m_cnt);
        check("R8 events", ev_seen, ev_exp);

        // R2 halted: phase and time have no effect
        for (int i = 0; i < 4; i++) begin phase_b = ~phase_b; cyc(3); end
        check("R2 halt hold", int'(count), m_cnt);

        // R13 direct load
        wr_cnt(7);
        cyc(1);
        check("R13 load", int'(count), 7);

        // R11 preload held until wrap
        wr_ceil(3, 1'b0);
        do_ug(1'b0, 0, 1'b0, 0, 1'b0);
        wr_ceil(5, 1'b1);
        run_ticks(6);
        check("R11 preload count", int'(count), m_cnt);
        check("R11 events", ev_seen, ev_exp);

        // R12 ug wins over direct load in the same cycle
        do_ug(1'b1, 50, 1'b0, 0, 1'b0);
        check("R12 ug over load", int'(count), 0);

        // R11 ug with preloaded write in same cycle takes new value
        do_ug(1'b0, 0, 1'b1, 2, 1'b1);
        run_ticks(3);
        check("R11 same-cycle ceiling", int'(count), m_cnt);
        check("R11 same-cycle events", ev_seen, ev_exp);
        check("R3 dir up", int'(dir_down), 0);

        // Encoder functions
        for (int md = 1; md <= 3; md++) begin
            string tag;
            tag = (md == 1) ? "R4 x2a" : (md == 2) ? "R5 x2b" : "R6 x4";
            enable = 1'b0;
            cyc(2);
            mode = 2'(md);
            wr_ceil(3 + int'($urandom % 10), 1'b0);
            do_ug(1'b0, 0, 1'b0, 0, 1'b0);
            enable = 1'b1;
            cyc(2);
            // directed down-wrap at zero
            if (md == 1) begin
                if (phase_a == phase_b) enc_move(phase_a, ~phase_b, tag);
                enc_move(phase_b, phase_b, "R9 down wrap");
            end else if (md == 2) begin
                if (phase_a == phase_b) enc_move(~phase_a, phase_b, tag);
                enc_move(phase_a, ~phase_b, "R9 down wrap");
            end
            for (int k = 0; k < 40; k++) begin
                if ($urandom % 2) enc_move(~phase_a, phase_b, tag);
                else              enc_move(phase_a, ~phase_b, tag);
            end
            check("R8 R9 encoder events", ev_seen, ev_exp);
            if (md == 3) begin
                enc_move(~phase_a, ~phase_b, "R6 simultaneous");
            end
            // R2 halted encoder edges ignored
            enable = 1'b0;
            cyc(2);
            phase_a = ~phase_a;
            cyc(5);
            check("R2 encoder halt", int'(count), m_cnt);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule